// File: doc/BRIEF.md
# Priority interrupt level controller

This block decides when a processor core leaves its instruction stream to service an interrupt. Interrupt sources present a single encoded level, where zero means no request and the all-ones code is the non-maskable level. The core reports each instruction boundary with a retire strobe. Requests are sampled only at those boundaries, and only when the level is strictly above the current mask.

When a request wins, the block first raises a save strobe for one cycle. In that cycle the mask output still carries the pre-interrupt value, so the core can push it with the rest of its status word. In the following cycle the block pulses take and presents the acknowledged level, and the mask now holds that level. Sampling then stays off until the handler's first instruction retires. That instruction may raise the mask further through a software mask write before the next decision is made.

A return-from-exception retire reloads the mask from a saved value given by the core. The top level is edge sensitive: it is remembered until it is taken, and a level held at the top does not fire twice.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, mask_o is 7 (all ones), and take_o and save_sr_o are low.
- R2: A decision is made only in a cycle where retire_i is high and no interrupt sequence is in progress. A level of 0 never starts a sequence, and no sequence starts while retire_i stays low.
- R3: A maskable level (1 to 6) is accepted only when it is strictly greater than the mask. Levels at or below the mask are held off; for example, a level 2 request is not taken while the mask is 3.
- R4: When a level is accepted on a boundary at clock edge N, save_sr_o is high for exactly the cycle after edge N, and mask_o then shows the pre-interrupt mask. take_o is high for exactly the cycle after edge N+1.
- R5: While take_o is high, ack_lvl_o equals the accepted level, and mask_o has already been loaded with that level.
- R6: After take_o, the next retire is not a decision point, even if a level above the new mask is pending. The retire after that one decides again.
- R7: A mask write (mask_wr_i with mask_wdata_i) is applied on a retire. On a decision boundary, the written value is the one compared against the level and the one presented during save_sr_o. On the handler's first retire, the written value becomes the new mask.
- R8: A rise of irq_lvl_i to 7 is accepted at the next decision boundary whatever the mask, with ack_lvl_o = 7. This holds even if the input has dropped below 7 again by then.
- R9: A level held at 7 after it has been taken is not taken again until the input falls below 7 and rises again.
- R10: A retire with rte_i high loads mask_o from rte_mask_i and is not a decision point. This applies both in the idle state and on a handler's first retire.
- R11: When rte_i and mask_wr_i are both high on the same retire, rte_mask_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 3 | Encoded pending interrupt level, 0 = none |
| retire_i | input | 1 | Instruction boundary strobe from the core |
| mask_wr_i | input | 1 | Software mask write, applied on a retire |
| mask_wdata_i | input | 3 | Value written to the mask |
| rte_i | input | 1 | The retiring instruction is a return from exception |
| rte_mask_i | input | 3 | Saved mask restored by a return from exception |
| save_sr_o | output | 1 | Core pushes its status word in this cycle |
| take_o | output | 1 | One-cycle pulse: interrupt taken |
| ack_lvl_o | output | 3 | Acknowledged level, valid with take_o |
| mask_o | output | 3 | Current interrupt mask |

## Verification
The assertions assume that the core issues no retire during the save and take cycles, because it is stalled while it pushes its status word. The stimulus honours this: after every boundary it waits through both cycles before the next retire. The assertions also assume that rte_mask_i and mask_wdata_i matter only on a retire, and the bench drives them only alongside retire_i. A sweep over every mask value against every maskable level covers the strict comparison. Directed sequences cover the handler's first retire, restore priority, and the edge-latched top level.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_TAKE = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             clr_i,
  output logic             req_o
);
  logic at_top, at_top_q, pend_q, rise;

  assign at_top = (lvl_i == {LVL_W{1'b1}});
  assign rise   = at_top & ~at_top_q;
  assign req_o  = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      at_top_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      at_top_q <= at_top;
      pend_q   <= clr_i ? 1'b0 : (pend_q | rise);
    end
  end

  // a rise not consumed is remembered (R8)
  p_rise_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !clr_i) |=> req_o);
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int LVL_W = 3
) (
  input  logic             boundary_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             nmi_req_i,
  output logic             accept_o,
  output logic             nmi_sel_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  logic maskable;

  // top level only enters through the edge path
  assign maskable  = (lvl_i != '0) && (lvl_i != TOP) && (lvl_i > mask_i);
  assign nmi_sel_o = boundary_i & nmi_req_i;
  assign accept_o  = boundary_i & (nmi_req_i | maskable);
  assign lvl_o     = nmi_req_i ? TOP : lvl_i;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_lvl_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             mask_wr_i,
  input  logic [LVL_W-1:0] mask_wdata_i,
  input  logic             rte_i,
  input  logic [LVL_W-1:0] rte_mask_i,
  input  logic             accept_i,
  input  logic [LVL_W-1:0] acc_lvl_i,
  output seq_state_e       state_o,
  output logic [LVL_W-1:0] eff_mask_o,
  output logic [LVL_W-1:0] mask_o,
  output logic [LVL_W-1:0] ack_lvl_o,
  output logic             save_o,
  output logic             take_o
);
  seq_state_e       state_q;
  logic [LVL_W-1:0] mask_q, ack_q, pend_q;

  // a write on the deciding retire governs that decision
  assign eff_mask_o = mask_wr_i ? mask_wdata_i : mask_q;
  assign state_o    = state_q;
  assign mask_o     = mask_q;
  assign ack_lvl_o  = ack_q;
  assign save_o     = (state_q == ST_SAVE);
  assign take_o     = (state_q == ST_TAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= {LVL_W{1'b1}};
      ack_q   <= '0;
      pend_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (retire_i) begin
          if (rte_i) mask_q <= rte_mask_i;
          else begin
            if (mask_wr_i) mask_q <= mask_wdata_i;
            if (accept_i) begin
              state_q <= ST_SAVE;
              pend_q  <= acc_lvl_i;
            end
          end
        end
        ST_SAVE: begin
          state_q <= ST_TAKE;
          mask_q  <= pend_q;
          ack_q   <= pend_q;
        end
        ST_TAKE: state_q <= ST_WAIT;
        ST_WAIT: if (retire_i) begin
          if (rte_i)          mask_q <= rte_mask_i;
          else if (mask_wr_i) mask_q <= mask_wdata_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_wait_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> (state_q != ST_SAVE));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             retire_i,
  input  logic             mask_wr_i,
  input  logic [LVL_W-1:0] mask_wdata_i,
  input  logic             rte_i,
  input  logic [LVL_W-1:0] rte_mask_i,
  output logic             save_sr_o,
  output logic             take_o,
  output logic [LVL_W-1:0] ack_lvl_o,
  output logic [LVL_W-1:0] mask_o
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  seq_state_e       state;
  logic             boundary, nmi_req, accept, nmi_sel;
  logic [LVL_W-1:0] eff_mask, acc_lvl;

  assign boundary = retire_i & (state == ST_IDLE) & ~rte_i;

  irq_nmi_edge #(.LVL_W(LVL_W)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(irq_lvl_i),
    .clr_i(nmi_sel), .req_o(nmi_req)
  );

  irq_accept #(.LVL_W(LVL_W)) u_acc (
    .boundary_i(boundary), .lvl_i(irq_lvl_i), .mask_i(eff_mask),
    .nmi_req_i(nmi_req), .accept_o(accept), .nmi_sel_o(nmi_sel), .lvl_o(acc_lvl)
  );

  irq_seq #(.LVL_W(LVL_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .rte_i(rte_i), .rte_mask_i(rte_mask_i),
    .accept_i(accept), .acc_lvl_i(acc_lvl), .state_o(state),
    .eff_mask_o(eff_mask), .mask_o(mask_o), .ack_lvl_o(ack_lvl_o),
    .save_o(save_sr_o), .take_o(take_o)
  );

  p_save_on_boundary_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_sr_o) |-> $past(retire_i));
  p_above_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && ack_lvl_o != TOP) |-> (ack_lvl_o > $past(mask_o)));
  p_save_then_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(save_sr_o));
  p_save_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_sr_o |=> (!save_sr_o && take_o));
  p_mask_is_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (mask_o == ack_lvl_o && ack_lvl_o != '0));
  p_take_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (!take_o && !save_sr_o));
  p_nmi_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req && boundary) |=> ##1 (take_o && ack_lvl_o == TOP));
endmodule

// File: tb/sim_irq_level_ctrl.sv
module sim_irq_level_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 50000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] irq_lvl = '0, wdata = '0, rmask = '0;
  logic       retire = 1'b0, mwr = 1'b0, rte = 1'b0;
  logic       save_sr, take;
  logic [2:0] ack_lvl, mask;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_lvl_i(irq_lvl), .retire_i(retire),
    .mask_wr_i(mwr), .mask_wdata_i(wdata), .rte_i(rte), .rte_mask_i(rmask),
    .save_sr_o(save_sr), .take_o(take), .ack_lvl_o(ack_lvl), .mask_o(mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one retire, then the save cycle, the take cycle, and a settling cycle
  task automatic step(input logic [2:0] lvl, input bit wr, input logic [2:0] wd,
                      input bit r, input logic [2:0] rm, input bit exp_take,
                      input logic [2:0] exp_lvl, input logic [2:0] save_mask,
                      input string req);
    irq_lvl = lvl; retire = 1'b1; mwr = wr; wdata = wd; rte = r; rmask = rm;
    @(negedge clk);
    retire = 1'b0; mwr = 1'b0; rte = 1'b0;
    chk(save_sr == exp_take, {req, " save"}, save_sr, exp_take);
    if (exp_take) chk(mask == save_mask, {req, " mask during save"}, mask, save_mask);
    @(negedge clk);
    chk(take == exp_take, {req, " take"}, take, exp_take);
    if (exp_take) begin
      chk(ack_lvl == exp_lvl, {req, " ack"}, ack_lvl, exp_lvl);
      chk(mask == exp_lvl, {req, " mask=ack R5"}, mask, exp_lvl);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(mask == 3'd7, "R1 mask", mask, 7);
    chk(!take && !save_sr, "R1 strobes", {take, save_sr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no retire, no decision
    step(3'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R2 level0");
    irq_lvl = 3'd5;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!save_sr && !take, "R2 no retire", {save_sr, take}, 0);
    end

    // R3 / R4 / R5 / R7 sweep: every mask against every maskable level
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 7; l++) begin
        bit t;
        step(3'd0, 1'b1, 3'(m), 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R7 write");
        chk(mask == 3'(m), "R7 mask written", mask, m);
        t = (l != 0) && (l > m);
        step(3'(l), 1'b0, 3'd0, 1'b0, 3'd0, t, 3'(l), 3'(m), "R3 compare");
        if (t) begin
          step(3'd0, 1'b0, 3'd0, 1'b1, 3'(m), 1'b0, 3'd0, 3'd0, "R10 exit");
          chk(mask == 3'(m), "R10 restore", mask, m);
        end
      end
    end

    // R3 example: mask 3 handler, level 2 pending
    step(3'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R3 setup");
    step(3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, 3'd0, "R3 take 3");
    step(3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R6 first retire");
    step(3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R3 level2 held");
    step(3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R3 level2 still held");

    // R6: pending 5 above mask 3 skipped on first retire, taken on second
    step(3'd0, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R6 setup");
    step(3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, 3'd1, "R6 take 3");
    step(3'd5, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R6 inhibit");
    step(3'd5, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 3'd3, "R6 nested");
    step(3'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 3'd0, "R10 in handler");
    chk(mask == 3'd3, "R10 mask", mask, 3);

    // R7: write on deciding retire lowers mask; handler's first retire raises it
    step(3'd0, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R7 setup");
    step(3'd4, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 3'd4, 3'd2, "R7 decide");
    step(3'd6, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R7 raise");
    chk(mask == 3'd6, "R7 raised", mask, 6);
    step(3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R7 blocked by raise");

    // R10 in idle: no decision; R11 priority
    step(3'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R10 setup");
    step(3'd3, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 3'd0, 3'd0, "R10 idle no decide");
    chk(mask == 3'd7, "R10 idle mask", mask, 7);
    step(3'd0, 1'b1, 3'd5, 1'b1, 3'd2, 1'b0, 3'd0, 3'd0, "R11 both");
    chk(mask == 3'd2, "R11 rte wins", mask, 2);

    // R8: top level latched, taken under mask 7
    step(3'd0, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R8 setup");
    irq_lvl = 3'd7;
    repeat (2) @(negedge clk);
    irq_lvl = 3'd0;
    repeat (2) @(negedge clk);
    chk(!save_sr, "R2 no retire top", save_sr, 0);
    step(3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd7, 3'd7, "R8 latched");
    step(3'd0, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 3'd0, 3'd0, "R8 exit");
    step(3'd7, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd7, 3'd7, "R8 edge");
    // R9: held at top
    step(3'd7, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 3'd0, 3'd0, "R9 exit");
    step(3'd7, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R9 held");
    step(3'd7, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, "R9 held mask0");
    irq_lvl = 3'd0;
    @(negedge clk);
    step(3'd7, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd7, 3'd0, "R8 re-edge");
    step(3'd7, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0, "R8 final exit");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule